// File: doc/BRIEF.md
# HDLC Receive Character Assembler with Residue Code

This block sits behind the zero-bit deletion stage of a bit-oriented synchronous receiver. It takes the cleaned serial stream one bit at a time, together with a strobe that marks each recognised flag pattern. It packs the bits into characters of a selectable length of 5 to 8 bits and hands them to the processor through a small receive FIFO with a valid/ready read handshake.

The CRC check itself is done elsewhere; the block only samples a CRC-OK input when the frame ends. When a closing flag arrives, the block pushes any partial character. In the same clock it latches a 3-bit residue code, an end-of-frame bit and a CRC-error bit. The residue code tells software where the information field stops inside the last characters, so that the frame can be retransmitted bit-exact without the trailing 16 CRC bits. The code bypasses the FIFO. Software therefore sees it as soon as the final character is written, even while earlier characters are still waiting to be read.

The latched status holds until software acknowledges it. The next flag that opens a frame then clears it.

Top module: `hdlc_residue_rx`

## Requirements
- R1: After reset, rd_valid, residue (000), frame_end, crc_err and overrun are all 0.
- R2: Data bits that arrive before the first flag after reset are discarded. When rx_flag and rx_bit_en are high in the same cycle, the flag is processed and the bit is discarded.
- R3: The character length is L = 5 + char_sel (00 gives 5 bits, 11 gives 8 bits). The first bit received goes to rd_data bit 0. A character enters the FIFO when its L-th bit arrives, and rd_data bits L..7 are always 0.
- R4: A flag that follows at least one data bit closes the frame. If k>0 bits of a character are pending, they are pushed right-aligned, with the upper bits zero. frame_end is 1 from the next cycle on.
- R5: At each closing flag, residue is loaded in the same clock edge as the final push, whatever the FIFO occupancy, and it holds its value otherwise. With N data bits in the frame and m = (N-16) mod L, let r be the value in 0..L-1 with (r + 2L - 14) mod L = m. Then residue[2] = r[0], residue[1] = r[1] and residue[0] = r[2].
- R6: With 8-bit characters, information-bit counts m = 0..7 map to residue codes (bits 2,1,0) 011, 111, 000, 100, 010, 110, 001, 101. With 7-bit characters, m = 1..5 map to 100, 010, 110, 001, 101.
- R7: At a closing flag, crc_err is loaded with the inverse of crc_ok.
- R8: status_ack is counted only while frame_end is 1. A flag that closes no frame clears frame_end and crc_err only if an acknowledge was counted since the last closing flag; otherwise both keep their values.
- R9: The FIFO holds 4 characters in arrival order. rd_valid is 1 while it is not empty, and an entry is removed on a cycle with rd_valid and rd_ready both 1.
- R10: A push that finds 4 entries stored (counted before that cycle's read) is dropped. It sets overrun, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit_en | input | 1 | A received data bit is present this cycle |
| rx_bit | input | 1 | Received data bit after zero deletion |
| rx_flag | input | 1 | Strobe: a flag pattern was recognised |
| char_sel | input | 2 | Character length select, L = 5 + char_sel |
| crc_ok | input | 1 | CRC check result, sampled at the closing flag |
| status_ack | input | 1 | Software acknowledge of the latched frame status |
| rd_ready | input | 1 | Reader accepts the FIFO head this cycle |
| rd_valid | output | 1 | FIFO head holds a character |
| rd_data | output | 8 | FIFO head character, right-aligned |
| residue | output | 3 | Residue code of the last closed frame |
| frame_end | output | 1 | End of frame latched |
| crc_err | output | 1 | CRC error latched |
| overrun | output | 1 | Sticky FIFO overrun |

## Verification
The bench builds the block with its defaults: 8-bit maximum character width, 16 CRC bits and a 4-entry FIFO. It selects all four character lengths at run time, so the residue arithmetic is exercised for each L. With a depth of 4, a single 8-bit frame of 56 bits fills the FIFO while reads are held off and then reaches overrun, and a 27-bit frame fills it exactly. That makes both the full-FIFO residue update and the dropped push reachable in a few hundred cycles.

// File: rtl/hdlc_rxr_pkg.sv
package hdlc_rxr_pkg;

  localparam int MIN_LEN   = 5;
  localparam int REV_BIAS  = 14;
  localparam int REV_SLOPE = 2;

  function automatic int char_len(input logic [1:0] sel);
    return MIN_LEN + int'(sel);
  endfunction

  // phase: bits pending in the current character at the closing flag
  function automatic logic [2:0] residue_code(input int len, input int phase,
                                              input int crc_bits);
    int info_rem;
    int rev;
    logic [2:0] r;
    info_rem = ((phase - (crc_bits % len)) % len + len) % len;
    rev      = ((info_rem + REV_BIAS - REV_SLOPE * len) % len + len) % len;
    r        = 3'(rev);
    return {r[0], r[1], r[2]};
  endfunction

endpackage

// File: rtl/hdlc_rxr_assemble.sv
module hdlc_rxr_assemble
  import hdlc_rxr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic                        bit_in,
  input  logic                        flag_in,
  input  logic [1:0]                  char_sel,
  output logic                        wr_en,
  output logic [CHAR_W-1:0]           wr_data,
  output logic                        close_evt,
  output logic                        open_evt,
  output logic [$clog2(CHAR_W)-1:0]   close_phase
);
  localparam int PH_W = $clog2(CHAR_W);

  logic              armed;
  logic              got_bits;
  logic [PH_W-1:0]   ph;
  logic [CHAR_W-1:0] chr;
  logic [CHAR_W-1:0] chr_next;
  logic [PH_W:0]     len;
  logic              take_bit;
  logic              last_bit;
  logic              full_push;
  logic              tail_push;

  assign len       = (PH_W+1)'(char_len(char_sel));
  assign take_bit  = bit_en && !flag_in && armed;
  assign last_bit  = ({1'b0, ph} == len - (PH_W+1)'(1));
  assign chr_next  = chr | (CHAR_W'(bit_in) << ph);
  assign close_evt = flag_in && armed && got_bits;
  assign open_evt  = flag_in && !(armed && got_bits);
  assign full_push = take_bit && last_bit;
  assign tail_push = close_evt && (ph != '0);
  assign wr_en     = full_push || tail_push;
  assign wr_data   = full_push ? chr_next : chr;
  assign close_phase = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      got_bits <= 1'b0;
      ph       <= '0;
      chr      <= '0;
    end else if (flag_in) begin
      armed    <= 1'b1;
      got_bits <= 1'b0;
      ph       <= '0;
      chr      <= '0;
    end else if (take_bit) begin
      got_bits <= 1'b1;
      if (last_bit) begin
        ph  <= '0;
        chr <= '0;
      end else begin
        ph  <= ph + PH_W'(1);
        chr <= chr_next;
      end
    end
  end

  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ph} < len));
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data >> len) == '0));
  assert_hunt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_en);

endmodule

// File: rtl/hdlc_rxr_status.sv
module hdlc_rxr_status
  import hdlc_rxr_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int CRC_BITS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      close_evt,
  input  logic                      open_evt,
  input  logic [$clog2(CHAR_W)-1:0] close_phase,
  input  logic [1:0]                char_sel,
  input  logic                      crc_ok,
  input  logic                      status_ack,
  output logic [2:0]                residue,
  output logic                      frame_end,
  output logic                      crc_err
);
  logic acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      residue   <= 3'b000;
      frame_end <= 1'b0;
      crc_err   <= 1'b0;
      acked     <= 1'b0;
    end else if (close_evt) begin
      residue   <= residue_code(char_len(char_sel), int'(close_phase), CRC_BITS);
      frame_end <= 1'b1;
      crc_err   <= !crc_ok;
      acked     <= 1'b0;
    end else if (open_evt && acked) begin
      frame_end <= 1'b0;
      crc_err   <= 1'b0;
      acked     <= 1'b0;
    end else if (status_ack && frame_end) begin
      acked     <= 1'b1;
    end
  end

  assert_eof_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> frame_end);
  assert_residue_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> $stable(residue));
  assert_crc_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (crc_err == !$past(crc_ok)));
  assert_clear_on_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_end) |-> $past(open_evt));

endmodule

// File: rtl/hdlc_rxr_fifo.sv
module hdlc_rxr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] count;
  logic          full;
  logic          accept;
  logic          pop;

  assign full     = (count == CW'(DEPTH));
  assign accept   = wr_en && !full;
  assign rd_valid = (count != '0);
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[e] <= '0;
        else if (accept && (wptr == AW'(e)))
          mem[e] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wptr <= bump(wptr);
      if (pop)    rptr <= bump(rptr);
      count <= count + CW'(accept) - CW'(pop);
      if (wr_en && full) overrun <= 1'b1;
    end
  end

  assert_overrun_on_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overrun);
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_drain_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en) |=> (count == $past(count) - CW'(1)));

endmodule

// File: rtl/hdlc_residue_rx.sv
module hdlc_residue_rx #(
  parameter int CHAR_W     = 8,
  parameter int CRC_BITS   = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_en,
  input  logic              rx_bit,
  input  logic              rx_flag,
  input  logic [1:0]        char_sel,
  input  logic              crc_ok,
  input  logic              status_ack,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_data,
  output logic [2:0]        residue,
  output logic              frame_end,
  output logic              crc_err,
  output logic              overrun
);
  localparam int PH_W = $clog2(CHAR_W);

  logic              push_evt;
  logic [CHAR_W-1:0] push_data;
  logic              close_evt;
  logic              open_evt;
  logic [PH_W-1:0]   close_phase;

  hdlc_rxr_assemble #(.CHAR_W(CHAR_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .bit_in(rx_bit),
    .flag_in(rx_flag), .char_sel(char_sel), .wr_en(push_evt),
    .wr_data(push_data), .close_evt(close_evt), .open_evt(open_evt),
    .close_phase(close_phase)
  );

  hdlc_rxr_status #(.CHAR_W(CHAR_W), .CRC_BITS(CRC_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .close_evt(close_evt), .open_evt(open_evt),
    .close_phase(close_phase), .char_sel(char_sel), .crc_ok(crc_ok),
    .status_ack(status_ack), .residue(residue), .frame_end(frame_end),
    .crc_err(crc_err)
  );

  hdlc_rxr_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push_evt), .wr_data(push_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .overrun(overrun)
  );

  // residue must move only together with a frame close (same edge as final push)
  assert_residue_with_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(residue) |-> $past(close_evt));

endmodule

// File: tb/test_hdlc_residue_rx.sv
`timescale 1ns/1ps
module test_hdlc_residue_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       rx_bit_en = 1'b0, rx_bit = 1'b0, rx_flag = 1'b0;
  logic [1:0] char_sel = 2'd3;
  logic       crc_ok = 1'b1, status_ack = 1'b0, rd_ready = 1'b1;
  logic       rd_valid, frame_end, crc_err, overrun;
  logic [7:0] rd_data;
  logic [2:0] residue;

  hdlc_residue_rx i_hdlc_residue_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .rx_flag(rx_flag), .char_sel(char_sel), .crc_ok(crc_ok),
    .status_ack(status_ack), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .residue(residue), .frame_end(frame_end),
    .crc_err(crc_err), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int seed = 32'h1d2c3b4a;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_code(input int nbits, input int len);
    int m, rev;
    m = (((nbits - 16) % len) + len) % len;
    rev = 0;
    for (int r = 0; r < len; r++)
      if ((((r + 2 * len - 14) % len) + len) % len == m) rev = r;
    return ((rev & 1) << 2) | (rev & 2) | ((rev >> 2) & 1);
  endfunction

  // behavioural reference model
  int q[$];
  int m_armed, m_got, m_ph, m_chr, m_nb, m_res, m_eof, m_crc, m_ovr, m_acked;
  int mL, m_pushv;
  bit m_full, m_pop, m_push;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_armed = 0; m_got = 0; m_ph = 0; m_chr = 0; m_nb = 0;
      m_res = 0; m_eof = 0; m_crc = 0; m_ovr = 0; m_acked = 0;
    end else begin
      mL = 5 + int'(char_sel);
      m_full = (q.size() >= 4);
      m_pop = (q.size() > 0) && rd_ready;
      m_push = 0;
      m_pushv = 0;
      if (rx_flag && m_armed != 0 && m_got != 0) begin
        if (m_ph > 0) begin m_push = 1; m_pushv = m_chr; end
        m_res = ref_code(m_nb, mL);
        m_eof = 1; m_crc = crc_ok ? 0 : 1; m_acked = 0;
      end else if (rx_flag && m_acked != 0) begin
        m_eof = 0; m_crc = 0; m_acked = 0;
      end else if (status_ack && m_eof != 0) begin
        m_acked = 1;
      end
      if (rx_flag) begin
        m_armed = 1; m_got = 0; m_ph = 0; m_chr = 0; m_nb = 0;
      end else if (rx_bit_en && m_armed != 0) begin
        m_chr = m_chr | (int'(rx_bit) << m_ph);
        m_ph++; m_nb++; m_got = 1;
        if (m_ph == mL) begin
          m_push = 1; m_pushv = m_chr; m_chr = 0; m_ph = 0;
        end
      end
      if (m_pop) void'(q.pop_front());
      if (m_push) begin
        if (m_full) m_ovr = 1;
        else q.push_back(m_pushv);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R9 rd_valid", int'(rd_valid), (q.size() > 0) ? 1 : 0);
      if (q.size() > 0) check("R3 rd_data", int'(rd_data), q[0]);
      check("R5 residue", int'(residue), m_res);
      check("R4 frame_end", int'(frame_end), m_eof);
      check("R7 crc_err", int'(crc_err), m_crc);
      check("R10 overrun", int'(overrun), m_ovr);
    end
  end

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      rx_flag = 1'b0; rx_bit_en = 1'b1; rx_bit = seed[3];
    end
    @(negedge clk);
    rx_bit_en = 1'b0;
  endtask

  task automatic send_flag(input logic ok);
    @(negedge clk);
    rx_bit_en = 1'b0; rx_flag = 1'b1; crc_ok = ok;
    @(negedge clk);
    rx_flag = 1'b0; crc_ok = 1'b1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); status_ack = 1'b1;
    @(negedge clk); status_ack = 1'b0;
  endtask

  task automatic frame(input int sel, input int info, input logic ok);
    @(negedge clk); char_sel = 2'(sel);
    send_flag(1'b1);
    send_bits(info + 16);
    send_flag(ok);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 residue", int'(residue), 0);
    check("R1 flags", int'({frame_end, crc_err, overrun}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: bits before the first flag are dropped
    send_bits(12);
    repeat (2) @(negedge clk);
    check("R2 hunt", int'(rd_valid), 0);

    // R6: 8-bit literal codes
    frame(3, 24 + 7, 1'b1); check("R6 8b m7", int'(residue), 3'b101);
    check("R4 eof", int'(frame_end), 1);
    // R8: no ack, idle flag keeps status
    send_flag(1'b1); check("R8 hold", int'(frame_end), 1);
    pulse_ack(); send_flag(1'b1); check("R8 clear", int'(frame_end), 0);
    frame(3, 24 + 0, 1'b1); check("R6 8b m0", int'(residue), 3'b011);
    frame(3, 24 + 1, 1'b1); check("R6 8b m1", int'(residue), 3'b111);
    frame(3, 24 + 2, 1'b1); check("R6 8b m2", int'(residue), 3'b000);
    frame(3, 24 + 3, 1'b1); check("R6 8b m3", int'(residue), 3'b100);
    frame(3, 24 + 4, 1'b1); check("R6 8b m4", int'(residue), 3'b010);
    // R6: 7-bit literal codes
    frame(2, 21 + 1, 1'b1); check("R6 7b m1", int'(residue), 3'b100);
    frame(2, 21 + 3, 1'b1); check("R6 7b m3", int'(residue), 3'b110);
    frame(2, 21 + 5, 1'b1); check("R6 7b m5", int'(residue), 3'b101);
    // R5: formula at 6 and 5 bits
    frame(1, 20, 1'b1); check("R5 6b", int'(residue), ref_code(36, 6));
    frame(0, 17, 1'b1); check("R5 5b", int'(residue), ref_code(33, 5));

    // R7 and R8 on crc error
    frame(3, 16, 1'b0); check("R7 crc_err", int'(crc_err), 1);
    send_flag(1'b1); check("R8 crc hold", int'(crc_err), 1);
    pulse_ack(); send_flag(1'b1); check("R8 crc clear", int'(crc_err), 0);

    // R5: residue updates while the FIFO still holds unread characters
    @(negedge clk); rd_ready = 1'b0;
    frame(3, 11, 1'b1);
    check("R5 fifo held", int'(rd_valid), 1);
    check("R5 held code", int'(residue), 3'b100);
    check("R10 no overrun", int'(overrun), 0);
    @(negedge clk); rd_ready = 1'b1;
    repeat (6) @(negedge clk);

    // R10: overrun with reads held off
    @(negedge clk); rd_ready = 1'b0;
    frame(3, 40, 1'b1);
    check("R10 overrun set", int'(overrun), 1);
    @(negedge clk); rd_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 sticky", int'(overrun), 1);
    check("R9 drained", int'(rd_valid), 0);

    // R2: flag and bit in the same cycle, the bit is dropped
    @(negedge clk); char_sel = 2'd3;
    send_flag(1'b1);
    send_bits(30);
    @(negedge clk); rx_flag = 1'b1; rx_bit_en = 1'b1; rx_bit = 1'b1;
    @(negedge clk); rx_flag = 1'b0; rx_bit_en = 1'b0;
    check("R2 flag wins", int'(residue), ref_code(30, 8));
    repeat (6) @(negedge clk);

    finish_run();
  end
endmodule